// File: doc/BRIEF.md
# Address-Filtered Serial Target on a Shared Select

This block is the target side of a four-wire serial bus on which many targets share one active-low select line. It has no dedicated select of its own. Every transaction opens with an address word that all targets on the bus receive at once. A target compares that word with its own address, which is fixed or strapped on `dev_addr`. The target whose address matches turns on its output driver and exchanges data words for the rest of the transaction. Every other target leaves its output released and disregards all traffic until select rises and falls again.

The bus runs in mode 0. Data is sampled on the rising serial clock edge and changed on the falling edge, with the most significant bit first. The serial pins are brought into the system clock domain through synchronizer flops, and edges are detected there. On the parallel side, the block gives one-cycle strobes: `rx_valid` with each received data word, and `tx_load` each time it captures the next transmit word from `tx_data`. The output pair `miso` / `miso_oe` drives a tri-state pad.

Top module: `shared_sel_spi_target`

## Requirements
- R1: After reset and whenever select is high (deasserted), `miso_oe` is 0. `rx_valid` and `tx_load` are 0 after reset.
- R2: While the address word is being shifted in, `miso_oe` stays 0, including when that address turns out to match.
- R3: When the eighth rising edge completes an address word equal to `dev_addr`, `miso_oe` goes to 1 before the first rising edge of the next word. It does so in the same cycle as a `tx_load` strobe.
- R4: If the address word differs from `dev_addr`, then for the rest of that transaction `miso_oe` stays 0, `rx_valid` never pulses and `tx_load` never pulses, whatever data follows.
- R5: After a match, each complete 8-bit data word raises `rx_valid` for exactly one clock. In that cycle `rx_data` holds the word, and the first bit sampled is bit 7.
- R6: While enabled, `miso` shows the loaded transmit word, bit 7 first. A new bit appears only after a falling serial clock edge or a load. The first bit of each word is valid before that word's first rising edge.
- R7: `tx_data` is captured at every word boundary of a matched transaction: after the address word and after each data word. Each capture gives a one-cycle `tx_load` pulse, and the captured word is sent in the following word.
- R8: Raising select in the middle of a word throws away the partial bits and resets word framing. The next transaction again starts with an address word, and the partial word produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | WORD_W | Strapped address of this target |
| sclk | input | 1 | Serial clock from the bus controller |
| cs_n | input | 1 | Shared active-low select line |
| mosi | input | 1 | Serial data from controller to targets |
| tx_data | input | WORD_W | Next word to transmit, captured at word boundaries |
| miso | output | 1 | Serial data from target to controller |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is captured |
| rx_valid | output | 1 | One-cycle pulse when a data word is received |
| rx_data | output | WORD_W | Last data word received |

## Verification
Several behaviours are checked on every cycle. The strobes must be single-cycle. A received word may only be reported while the output driver is enabled. The driver may only switch on together with a transmit load. The serial output may only move after a falling clock edge or a load. Other behaviours only the bench's scenarios can show. These are the address comparison itself, silence on a mismatch even when later data equals the address, the bit order of received and sent words, and the recovery of framing after a select abort in the middle of an address word or a data word.

// File: rtl/shared_sel_spi_target.sv
module shared_sel_spi_target #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] dev_addr,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [WORD_W-1:0] tx_data,
  output logic              miso,
  output logic              miso_oe,
  output logic              tx_load,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_SKIP} phase_t;

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic                   sclk_d;
  logic                   sclk_now, cs_now, mosi_now, rise, fall;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_W-1:0]      rx_sh, tx_sh, word_next;
  phase_t                 phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sclk_d    <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
      sclk_d    <= sclk_now;
    end
  end

  assign sclk_now  = sclk_sync[SYNC_STAGES-1];
  assign cs_now    = cs_sync[SYNC_STAGES-1];
  assign mosi_now  = mosi_sync[SYNC_STAGES-1];
  assign rise      = sclk_now & ~sclk_d;
  assign fall      = ~sclk_now & sclk_d;
  assign word_next = {rx_sh[WORD_W-2:0], mosi_now};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_ADDR;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (cs_now) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
      end else if (rise && phase != PH_SKIP) begin
        rx_sh <= word_next;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          if (phase == PH_ADDR) begin
            if (word_next == dev_addr) begin
              phase   <= PH_DATA;
              tx_sh   <= tx_data;
              tx_load <= 1'b1;
            end else begin
              phase <= PH_SKIP;
            end
          end else begin
            rx_data  <= word_next;
            rx_valid <= 1'b1;
            tx_sh    <= tx_data;
            tx_load  <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (fall && phase == PH_DATA && bit_cnt != '0) begin
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign miso    = tx_sh[WORD_W-1];
  assign miso_oe = (phase == PH_DATA) && !cs_now;
endmodule

// File: rtl/shared_sel_spi_target_chk.sv
module shared_sel_spi_target_chk (
  input logic clk,
  input logic rst_n,
  input logic miso,
  input logic miso_oe,
  input logic tx_load,
  input logic rx_valid,
  input logic fall_evt
);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  p_valid_needs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> miso_oe);

  p_oe_rise_with_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> tx_load);

  p_miso_moves_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$stable(miso)) |-> ($past(fall_evt) || tx_load));
endmodule

bind shared_sel_spi_target shared_sel_spi_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .miso     (miso),
  .miso_oe  (miso_oe),
  .tx_load  (tx_load),
  .rx_valid (rx_valid),
  .fall_evt (fall)
);

// File: tb/tb_shared_sel_spi_target.sv
module tb_shared_sel_spi_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_addr = 8'h5A;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       miso, miso_oe, tx_load, rx_valid;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  int load_cnt = 0;
  bit prev_valid = 0;
  int cs_high_cycles = 0;
  logic [7:0] got_rx[$];
  logic [7:0] exp_rx[$];

  shared_sel_spi_target dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .tx_data(tx_data), .miso(miso), .miso_oe(miso_oe),
    .tx_load(tx_load), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) got_rx.push_back(rx_data);
      if (tx_load) load_cnt++;
      if (prev_valid && rx_valid) chk(0, "R5 strobe width", 2, 1);
      prev_valid = rx_valid;
      cs_high_cycles = cs_n ? cs_high_cycles + 1 : 0;
      if (cs_high_cycles > 4 && miso_oe) chk(0, "R1 oe while deselected", 1, 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit exp_oe,
                           input logic [7:0] exp_tx, input string req);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      chk(miso_oe === exp_oe, req, miso_oe, exp_oe);
      if (exp_oe) chk(miso === exp_tx[i], "R6 miso bit", miso, exp_tx[i]);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic start_txn();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_txn();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
    chk(miso_oe === 1'b0, "R1 oe after deselect", miso_oe, 0);
  endtask

  task automatic matched_txn(input logic [7:0] addr, input logic [7:0] d[], input logic [7:0] t[]);
    logic [7:0] prev_tx;
    start_txn();
    tx_data = t[0];
    prev_tx = t[0];
    send_bits(addr, 8, 1'b0, 8'h00, "R2 oe during address");
    for (int k = 0; k < d.size(); k++) begin
      tx_data = t[k+1];
      send_bits(d[k], 8, 1'b1, prev_tx, "R3 oe after match");
      prev_tx = t[k+1];
      exp_rx.push_back(d[k]);
    end
    end_txn();
  endtask

  task automatic compare_rx(input string req);
    chk(got_rx.size() == exp_rx.size(), req, got_rx.size(), exp_rx.size());
    for (int k = 0; k < exp_rx.size() && k < got_rx.size(); k++)
      chk(got_rx[k] === exp_rx[k], req, got_rx[k], exp_rx[k]);
    got_rx.delete();
    exp_rx.delete();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] d[];
    logic [7:0] t[];
    wait_clk(4);
    chk(miso_oe === 1'b0, "R1 reset oe", miso_oe, 0);
    chk(rx_valid === 1'b0, "R1 reset rx_valid", rx_valid, 0);
    chk(tx_load === 1'b0, "R1 reset tx_load", tx_load, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R5 R6 R7: matched transaction with three data words
    d = '{8'hA3, 8'h3C, 8'hFF};
    t = '{8'h81, 8'h7E, 8'hC5, 8'h00};
    load_cnt = 0;
    matched_txn(8'h5A, d, t);
    compare_rx("R5 rx words");
    chk(load_cnt == 4, "R7 tx_load count", load_cnt, 4);

    // R4: mismatching address, then data equal to own address
    load_cnt = 0;
    start_txn();
    send_bits(8'h5B, 8, 1'b0, 8'h00, "R4 oe on mismatch addr");
    send_bits(8'h5A, 8, 1'b0, 8'h00, "R4 oe ignored data");
    send_bits(8'h11, 8, 1'b0, 8'h00, "R4 oe ignored data");
    end_txn();
    compare_rx("R4 no rx words");
    chk(load_cnt == 0, "R4 tx_load count", load_cnt, 0);

    // R8: abort mid-address, then a clean transaction
    start_txn();
    send_bits(8'hFF, 3, 1'b0, 8'h00, "R8 oe partial addr");
    end_txn();
    d = '{8'h96};
    t = '{8'h4B, 8'h00};
    matched_txn(8'h5A, d, t);
    compare_rx("R8 after addr abort");

    // R8: abort mid-data word, partial word discarded
    start_txn();
    tx_data = 8'hE1;
    send_bits(8'h5A, 8, 1'b0, 8'h00, "R2 oe during address");
    send_bits(8'hFF, 5, 1'b1, 8'hE1, "R8 oe partial data");
    end_txn();
    compare_rx("R8 partial data dropped");
    d = '{8'h01, 8'h80};
    t = '{8'h55, 8'hAA, 8'h00};
    matched_txn(8'h5A, d, t);
    compare_rx("R8 after data abort");

    // R3: different strapped address
    dev_addr = 8'h00;
    wait_clk(4);
    d = '{8'h12};
    t = '{8'hF0, 8'h00};
    matched_txn(8'h00, d, t);
    compare_rx("R3 strapped address");
    start_txn();
    send_bits(8'h5A, 8, 1'b0, 8'h00, "R4 old address ignored");
    send_bits(8'h34, 8, 1'b0, 8'h00, "R4 old address ignored");
    end_txn();
    compare_rx("R4 old address no rx");

    finish_run();
  end
endmodule